// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides one integer by another over several clock cycles, one quotient bit per cycle. When a division is issued, the block looks at the chosen operand size and at the magnitude of the dividend. It then runs only as many shift-and-subtract steps as the dividend has significant bits. Small values and narrow sizes therefore finish well before the worst case. Signed and unsigned operation are both supported, at 8, 16 or 32 bits.

A request is a single-cycle start strobe that carries the operands, a signed flag and a size code. The unit stays busy until it raises a one-cycle done pulse, which carries the quotient, the remainder and a divide-by-zero flag. Any start strobe that arrives while the unit is busy is dropped. The results stay on the outputs until the next request is accepted.

Top module: `itdiv_top`

## Requirements
- R1: A start strobe seen while busy is low is accepted. Busy rises on the next cycle, stays high through the cycle in which done is high, and is low on the cycle after done.
- R2: Done is high for exactly one cycle per accepted request.
- R3: A start strobe in any cycle where busy is high is ignored. This includes the done cycle. Such a strobe does not change the timing or results of the running division, and it starts no new division.
- R4: Let N be the number of significant bits in the magnitude of the size-extended dividend, with nonzero divisor and N > 0. Done then appears N+1 cycles after the accepting edge, so the 32-bit worst case is 33 cycles.
- R5: A divisor that is zero within the selected size gives done one cycle after acceptance. The divide-by-zero output is 1 and both quotient and remainder are 0.
- R6: With the signed flag at 0, quotient and remainder are the unsigned results, zero-extended to 32 bits.
- R7: With the signed flag at 1, the quotient truncates toward zero and the remainder carries the sign of the dividend (zero remainder is 0).
- R8: The size code selects the width: 0 means 8 bits, 1 means 16 bits, and 2 or 3 means 32 bits. Operand bits above the selected width are ignored. Each operand is sign-extended when the signed flag is 1 and zero-extended otherwise. Results are extended from the selected width in the same way.
- R9: A signed quotient that does not fit the selected width keeps only its low bits, then sign-extends (for example -128 / -1 at 8 bits gives 0xFFFFFF80).
- R10: A zero dividend with a nonzero divisor gives done one cycle after acceptance, with quotient 0, remainder 0 and divide-by-zero 0.
- R11: After reset, busy, done, quotient, remainder and divide-by-zero are all 0.
- R12: Quotient, remainder and divide-by-zero hold their values from the done cycle until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, honoured only while busy is low |
| dividend | input | 32 | Dividend; bits above the selected size are ignored |
| divisor | input | 32 | Divisor; bits above the selected size are ignored |
| is_signed | input | 1 | 1 for two's complement operands, 0 for unsigned |
| size_sel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 or 3 = 32 |
| busy | output | 1 | Unit occupied, from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient, extended from the selected width |
| remainder | output | 32 | Remainder, extended from the selected width |
| div_zero | output | 1 | Divisor was zero within the selected width |

## Verification
Two events can fall in the same cycle: the completion pulse and a new request strobe. The bench provokes this by holding start high with unrelated operands through a whole division, including the done cycle. The reference model treats the done cycle as busy, so it expects the strobe to be dropped. Any acceptance would show up as busy staying high after done, or as changed held results, and both are compared every clock. The same bench also runs operands whose significant-bit count is 0, 1 or the full width, so the skip-to-finish path is exercised next to the stepping path.

// File: rtl/itdiv_pkg.sv
package itdiv_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  // Operand width in bits for a size code; the widest codes follow w.
  function automatic int size_bits(size_e s, int w);
    case (s)
      SZ_BYTE: return 8;
      SZ_HALF: return 16;
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/itdiv_fit.sv
// Keeps the low bits of v that the size code selects and extends them
// to the full width, by sign when sgn is set, by zero otherwise.
module itdiv_fit
  import itdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] v,
  input  size_e        sz,
  input  logic         sgn,
  output logic [W-1:0] y
);

  always_comb begin
    int   b;
    logic top;
    b   = size_bits(sz, W);
    top = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i == b - 1) top = v[i];
    end
    for (int i = 0; i < W; i++) begin
      y[i] = (i < b) ? v[i] : (sgn & top);
    end
  end

endmodule

// File: rtl/itdiv_prep.sv
// Issue-time inspection: operand extension, magnitudes, result signs,
// significant-bit count of the dividend and its left alignment.
module itdiv_prep
  import itdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  input  size_e         sz,
  input  logic          sgn,
  output logic [W-1:0]  mag_d,
  output logic [W-1:0]  aligned,
  output logic [CW-1:0] nbits,
  output logic          neg_q,
  output logic          neg_r,
  output logic          dz
);

  function automatic logic [W-1:0] magnitude(logic [W-1:0] x, logic neg);
    return neg ? (~x + 1'b1) : x;
  endfunction

  function automatic int sig_bits(logic [W-1:0] x);
    int n;
    n = 0;
    for (int i = 0; i < W; i++) begin
      if (x[i]) n = i + 1;
    end
    return n;
  endfunction

  logic [W-1:0] ext_n, ext_d, mag_n;
  logic         sn, sd;

  itdiv_fit #(.W(W)) u_fit_n (.v(dividend), .sz(sz), .sgn(sgn), .y(ext_n));
  itdiv_fit #(.W(W)) u_fit_d (.v(divisor),  .sz(sz), .sgn(sgn), .y(ext_d));

  always_comb begin
    int cnt;
    sn    = sgn & ext_n[W-1];
    sd    = sgn & ext_d[W-1];
    mag_n = magnitude(ext_n, sn);
    mag_d = magnitude(ext_d, sd);
    dz    = (ext_d == '0);
    neg_q = sn ^ sd;
    neg_r = sn;
    cnt   = dz ? 0 : sig_bits(mag_n);
    nbits = CW'(cnt);
    aligned = (cnt == 0) ? '0 : (mag_n << (W - cnt));
  end

endmodule

// File: rtl/itdiv_core.sv
// Restoring shift-subtract datapath with a step counter loaded at issue.
module itdiv_core #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  d_in,
  input  logic [CW-1:0] n_in,
  output logic [W-1:0]  q_mag,
  output logic [W-1:0]  r_mag,
  output logic          step_fire,
  output logic          last_step
);

  logic [W-1:0]  acc, sh, qr, dv;
  logic [CW-1:0] cnt;
  logic [W:0]    trial, diff;
  logic          qbit;

  always_comb begin
    trial = {acc, sh[W-1]};
    diff  = trial - {1'b0, dv};
    qbit  = (trial >= {1'b0, dv});
  end

  assign step_fire = (cnt != '0);
  assign last_step = (cnt == CW'(1));
  assign q_mag     = qr;
  assign r_mag     = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      sh  <= '0;
      qr  <= '0;
      dv  <= '0;
      cnt <= '0;
    end else if (load) begin
      acc <= '0;
      sh  <= a_in;
      qr  <= '0;
      dv  <= d_in;
      cnt <= n_in;
    end else if (step_fire) begin
      acc <= qbit ? diff[W-1:0] : trial[W-1:0];
      sh  <= {sh[W-2:0], 1'b0};
      qr  <= {qr[W-2:0], qbit};
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/itdiv_fix.sv
// Applies result signs and fits quotient and remainder to the size.
module itdiv_fix
  import itdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         neg_q,
  input  logic         neg_r,
  input  size_e        sz,
  input  logic         sgn,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);

  function automatic logic [W-1:0] apply_sign(logic [W-1:0] m, logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  logic [W-1:0] q_raw, r_raw;

  assign q_raw = apply_sign(q_mag, neg_q);
  assign r_raw = apply_sign(r_mag, neg_r);

  itdiv_fit #(.W(W)) u_fit_q (.v(q_raw), .sz(sz), .sgn(sgn), .y(q_out));
  itdiv_fit #(.W(W)) u_fit_r (.v(r_raw), .sz(sz), .sgn(sgn), .y(r_out));

endmodule

// File: rtl/itdiv_top.sv
module itdiv_top
  import itdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic [1:0]   size_sel,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);

  localparam int CW = $clog2(W + 1);

  state_e        st_q, st_d;
  size_e         sz_in, sz_q;
  logic          sgn_q, neg_q_q, neg_r_q, dz_q;
  logic [W-1:0]  mag_d, aligned, q_mag, r_mag;
  logic [CW-1:0] nbits;
  logic          neg_q, neg_r, dz;
  logic          accept, step_fire, last_step;

  assign sz_in  = size_e'(size_sel);
  assign accept = start && (st_q == ST_IDLE);

  itdiv_prep #(.W(W), .CW(CW)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .sz       (sz_in),
    .sgn      (is_signed),
    .mag_d    (mag_d),
    .aligned  (aligned),
    .nbits    (nbits),
    .neg_q    (neg_q),
    .neg_r    (neg_r),
    .dz       (dz)
  );

  itdiv_core #(.W(W), .CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .a_in      (aligned),
    .d_in      (mag_d),
    .n_in      (nbits),
    .q_mag     (q_mag),
    .r_mag     (r_mag),
    .step_fire (step_fire),
    .last_step (last_step)
  );

  itdiv_fix #(.W(W)) u_fix (
    .q_mag (q_mag),
    .r_mag (r_mag),
    .neg_q (neg_q_q),
    .neg_r (neg_r_q),
    .sz    (sz_q),
    .sgn   (sgn_q),
    .q_out (quotient),
    .r_out (remainder)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = (nbits == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (last_step) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sz_q    <= SZ_WORD;
      sgn_q   <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        sz_q    <= sz_in;
        sgn_q   <= is_signed;
        neg_q_q <= neg_q;
        neg_r_q <= neg_r;
        dz_q    <= dz;
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign div_zero = dz_q;

endmodule

// File: rtl/itdiv_chk.sv
module itdiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         step_fire
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (busy && !done) run_len <= run_len + 1;
    else run_len <= 0;
  end

  AST_ACCEPT_RISE: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R1
  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R1
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_STEP_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) step_fire |-> (busy && !done)); // R4
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (run_len <= W)); // R4
  AST_DZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && div_zero) |-> (quotient == '0 && remainder == '0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero))); // R12

endmodule

bind itdiv_top itdiv_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .div_zero  (div_zero),
  .quotient  (quotient),
  .remainder (remainder),
  .step_fire (step_fire)
);

// File: tb/itdiv_top_tb_top.sv
`timescale 1ns/1ps
module itdiv_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        is_signed = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        busy, done, div_zero;
  logic [31:0] quotient, remainder;

  always #5 clk = ~clk;

  itdiv_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .is_signed(is_signed), .size_sel(size_sel),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_tag = "R11";

  // reference model state
  bit          m_busy = 0;
  int          m_left = 0;
  logic [31:0] m_q = '0, m_r = '0;
  bit          m_dz = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int width_of(logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic longint opval(logic [31:0] v, int b, bit sg);
    longint m;
    m = longint'(v) & ((64'sd1 <<< b) - 1);
    if (sg && m[b-1]) m = m - (64'sd1 <<< b);
    return m;
  endfunction

  function automatic logic [31:0] resfit(longint v, int b, bit sg);
    longint m;
    m = v & ((64'sd1 <<< b) - 1);
    if (sg && m[b-1]) m = m - (64'sd1 <<< b);
    return m[31:0];
  endfunction

  task automatic model_issue(logic [31:0] a, logic [31:0] d, logic [1:0] s, bit sg);
    int b, n;
    longint av, dv, mag;
    b  = width_of(s);
    av = opval(a, b, sg);
    dv = opval(d, b, sg);
    m_busy = 1;
    if (dv == 0) begin
      m_q = '0; m_r = '0; m_dz = 1; m_left = 0;
    end else begin
      m_dz = 0;
      m_q = resfit(av / dv, b, sg);
      m_r = resfit(av % dv, b, sg);
      mag = (av < 0) ? -av : av;
      n = 0;
      while (mag != 0) begin n++; mag = mag >>> 1; end
      m_left = n;   // done appears n+1 edges after acceptance (1 when n==0)
    end
  endtask

  // one clock: check this cycle, drive the next edge, advance the model
  task automatic step(input bit st, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] s, input bit sg);
    bit m_done;
    @(negedge clk);
    m_done = m_busy && (m_left == 0);
    chk(busy == m_busy, "R1", "busy", 32'(busy), 32'(m_busy));
    chk(done == m_done, "R4", "done timing", 32'(done), 32'(m_done)); // R2 pulse shape too
    if (m_done) begin
      chk(quotient == m_q, cur_tag, "quotient", quotient, m_q);
      chk(remainder == m_r, cur_tag, "remainder", remainder, m_r);
      chk(div_zero == m_dz, cur_tag, "div_zero", 32'(div_zero), 32'(m_dz));
    end else if (!m_busy) begin
      chk(quotient == m_q, "R12", "held quotient", quotient, m_q);
      chk(remainder == m_r, "R12", "held remainder", remainder, m_r);
      chk(div_zero == m_dz, "R12", "held div_zero", 32'(div_zero), 32'(m_dz));
    end
    start = st; dividend = a; divisor = d; size_sel = s; is_signed = sg;
    if (m_busy) begin
      if (m_left == 0) m_busy = 0;
      else m_left--;
    end else if (st) begin
      model_issue(a, d, s, sg);
    end
  endtask

  // issue one division; poke keeps start high with junk operands while busy (R3)
  task automatic op(input string tag, input logic [31:0] a, input logic [31:0] d,
                    input logic [1:0] s, input bit sg, input bit poke);
    cur_tag = tag;
    step(1'b1, a, d, s, sg);
    while (m_busy) begin
      if (poke) step(1'b1, 32'h7FFF_FFFF, 32'h3, 2'd2, 1'b0);
      else      step(1'b0, '0, '0, 2'd0, 1'b0);
    end
    step(1'b0, '0, '0, 2'd0, 1'b0);
    step(1'b0, '0, '0, 2'd0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(busy == 0 && done == 0, "R11", "busy/done in reset", {30'd0, busy, done}, '0);
    chk(quotient == 0 && remainder == 0 && div_zero == 0, "R11", "results in reset",
        quotient | remainder | 32'(div_zero), '0);
    rst_n = 1'b1;
    repeat (2) step(1'b0, '0, '0, 2'd0, 1'b0);

    op("R6", 32'd200, 32'd7, 2'd0, 1'b0, 0);
    op("R8", 32'hABCD_12C8, 32'hFFFF_FF07, 2'd0, 1'b0, 0);   // upper bits ignored
    op("R7", 32'hFFFF_FF9C, 32'd7, 2'd0, 1'b1, 0);           // -100 / 7
    op("R7", 32'd100, 32'hFFFF_FFF9, 2'd0, 1'b1, 0);         // 100 / -7
    op("R7", 32'hFFFF_FF9C, 32'hFFFF_FFF9, 2'd0, 1'b1, 0);   // -100 / -7
    op("R7", 32'h0000_8AD0, 32'd123, 2'd1, 1'b1, 0);         // -30000 / 123 at 16
    op("R6", 32'hFFFF_FFFF, 32'd3, 2'd2, 1'b0, 0);           // 33-cycle case (R4)
    op("R4", 32'd5, 32'd2, 2'd2, 1'b1, 0);                   // three steps
    op("R4", 32'd1, 32'd1, 2'd2, 1'b0, 0);                   // single step
    op("R5", 32'd1234, 32'd0, 2'd2, 1'b1, 0);
    op("R5", 32'd55, 32'hABCD_EF00, 2'd0, 1'b0, 0);          // zero in low byte
    op("R10", 32'd0, 32'd9, 2'd1, 1'b1, 0);
    op("R9", 32'h0000_0080, 32'h0000_00FF, 2'd0, 1'b1, 0);   // -128 / -1 at 8
    op("R9", 32'h8000_0000, 32'hFFFF_FFFF, 2'd2, 1'b1, 0);
    op("R8", 32'h8000_0000, 32'd3, 2'd3, 1'b1, 0);           // code 3 acts as 32
    op("R8", 32'h1234_F000, 32'h0000_0010, 2'd1, 1'b0, 0);   // 16-bit unsigned
    op("R3", 32'hFFFF_FFFF, 32'd10, 2'd2, 1'b0, 1);          // start held while busy
    op("R3", 32'd0, 32'd5, 2'd0, 1'b0, 1);                   // strobe in done cycle
    op("R3", 32'd77, 32'd0, 2'd1, 1'b1, 1);
    for (int k = 0; k < 60; k++) begin
      logic [31:0] ra, rd;
      ra = $urandom;
      rd = (k % 5 == 0) ? ($urandom & 32'hF) : $urandom >> (k % 29);
      op((k % 2) ? "R7" : "R6", ra >> (k % 31), rd, 2'(k % 4), 1'(k % 2), 1'(k % 3 == 0));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule